// File: doc/BRIEF.md
# Lamp Clock Divider

This block turns a fast board oscillator into the slow square waves a bicycle lamp controller runs on. With its default ratios it turns an 8 MHz oscillator into a 1 kHz system clock for the lamp state machine and a 5 Hz blink clock. It also adds a 500 Hz tap, which can drive the lamp at half brightness. Every output has exactly 50% duty. The raw oscillator is also passed through to a separate pin so it can be probed.

A first counter wraps every `DIV_FAST` oscillator cycles and gives a one-cycle enable; with the defaults this enable runs at 2 kHz. A second counter wraps once every `DIV_SLOW` of those enables and gives a 10 Hz enable. Toggle flip-flops square each enable into an output. The 500 Hz tap toggles each time the 1 kHz output falls. Both ratios are parameters, so a bench can shrink them and keep the same structure.

Top module: `lamp_clk_gen`

## Requirements
- R1: `oscOut` equals `oscIn` at all times, as a pure combinational pass-through.
- R2: While `rstN` is low, `sysClkOut`, `blinkClkOut` and `halfClkOut` are 0. They clear as soon as reset asserts, with no oscillator edge needed.
- R3: Let k be the number of rising `oscIn` edges since `rstN` went high. After edge k, `sysClkOut` equals floor(k / DIV_FAST) mod 2. It therefore holds each level for exactly DIV_FAST cycles.
- R4: After edge k, `blinkClkOut` equals floor(k / (DIV_FAST*DIV_SLOW)) mod 2.
- R5: After edge k, `halfClkOut` equals floor(k / (2*DIV_FAST)) mod 2. It changes exactly on the edges where `sysClkOut` falls.
- R6: `blinkClkOut` changes only on an edge where `sysClkOut` also changes.
- R7: Asserting reset in the middle of a run restarts the count. After release, the outputs follow R3 to R5 again from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscIn | input | 1 | Board oscillator; clocks all registers |
| rstN | input | 1 | Asynchronous reset, active low |
| oscOut | output | 1 | Oscillator pass-through for probing |
| sysClkOut | output | 1 | Square wave at oscIn / (2*DIV_FAST), 1 kHz by default |
| blinkClkOut | output | 1 | Square wave at oscIn / (2*DIV_FAST*DIV_SLOW), 5 Hz by default |
| halfClkOut | output | 1 | Square wave at half the sysClkOut rate |

## Verification
A fast counter that is off by one shows up at `sysClkOut` within one output half-period. In that case the first edge after reset lands one cycle early or late, which the per-cycle model catches. A fault in the slow counter or in the 500 Hz toggle appears at `blinkClkOut` or `halfClkOut` by the end of their first half-period. The same fault also breaks their alignment with `sysClkOut`. A reset that fails to clear a register shows as a nonzero output in the half-cycle before the next oscillator edge.

// File: rtl/lamp_clk_pkg.sv
package lamp_clk_pkg;
  // One-cycle enables from the counter chain to the toggle stage.
  typedef struct packed {
    logic tickFast;  // end of a fast-counter wrap
    logic tickSlow;  // end of a slow-counter wrap (subset of tickFast)
  } tickStrobes_t;
endpackage

// File: rtl/lamp_clk_ctrl.sv
module lamp_clk_ctrl
  import lamp_clk_pkg::*;
#(
  parameter int DIV_FAST = 4000,
  parameter int DIV_SLOW = 200
) (
  input  logic         clk,
  input  logic         rstN,
  output tickStrobes_t ticks
);
  localparam int FAST_W = (DIV_FAST > 2) ? $clog2(DIV_FAST) : 1;
  localparam int SLOW_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(DIV_FAST - 1);
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(DIV_SLOW - 1);

  logic [FAST_W-1:0] fastCnt;
  logic [SLOW_W-1:0] slowCnt;
  logic              fastWrap;
  logic              slowWrap;

  assign fastWrap = (fastCnt == FAST_LAST);
  assign slowWrap = fastWrap && (slowCnt == SLOW_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastCnt <= '0;
    end else if (fastWrap) begin
      fastCnt <= '0;
    end else begin
      fastCnt <= fastCnt + 1'b1;
    end
  end

  // The slow counter advances only on fast wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowCnt <= '0;
    end else if (slowWrap) begin
      slowCnt <= '0;
    end else if (fastWrap) begin
      slowCnt <= slowCnt + 1'b1;
    end
  end

  assign ticks.tickFast = fastWrap;
  assign ticks.tickSlow = slowWrap;
endmodule

// File: rtl/lamp_clk_dp.sv
module lamp_clk_dp
  import lamp_clk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  tickStrobes_t ticks,
  output logic         sysClk,
  output logic         blinkClk,
  output logic         halfClk
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysClk   <= 1'b0;
      blinkClk <= 1'b0;
      halfClk  <= 1'b0;
    end else begin
      if (ticks.tickFast) sysClk <= ~sysClk;
      if (ticks.tickSlow) blinkClk <= ~blinkClk;
      // Toggle on the fast tick that takes sysClk from high to low.
      if (ticks.tickFast && sysClk) halfClk <= ~halfClk;
    end
  end
endmodule

// File: rtl/lamp_clk_gen.sv
module lamp_clk_gen #(
  parameter int DIV_FAST = 4000,
  parameter int DIV_SLOW = 200
) (
  input  logic oscIn,
  input  logic rstN,
  output logic oscOut,
  output logic sysClkOut,
  output logic blinkClkOut,
  output logic halfClkOut
);
  lamp_clk_pkg::tickStrobes_t ticks;

  assign oscOut = oscIn;

  lamp_clk_ctrl #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW)
  ) uCtrl (
    .clk  (oscIn),
    .rstN (rstN),
    .ticks(ticks)
  );

  lamp_clk_dp uDp (
    .clk     (oscIn),
    .rstN    (rstN),
    .ticks   (ticks),
    .sysClk  (sysClkOut),
    .blinkClk(blinkClkOut),
    .halfClk (halfClkOut)
  );
endmodule

// File: rtl/lamp_clk_gen_chk.sv
module lamp_clk_gen_chk #(
  parameter int DIV_FAST = 4000
) (
  input logic oscIn,
  input logic rstN,
  input logic sysClkOut,
  input logic blinkClkOut,
  input logic halfClkOut
);
  localparam int CW = $clog2(DIV_FAST + 2) + 1;
  localparam logic [CW-1:0] HOLD = CW'(DIV_FAST);

  // Counts sampled edges since sysClkOut last changed level.
  logic [CW-1:0] sinceSys;
  logic          lastSys;

  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) begin
      sinceSys <= '0;
      lastSys  <= 1'b0;
    end else begin
      sinceSys <= (sysClkOut != lastSys) ? CW'(1) : sinceSys + 1'b1;
      lastSys  <= sysClkOut;
    end
  end

  // R3: each level of sysClkOut lasts exactly DIV_FAST cycles
  assert_sys_hold_R3: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(sysClkOut) |-> (sinceSys == HOLD));

  // R3: sysClkOut never stays at one level longer than DIV_FAST cycles
  assert_sys_no_stall_R3: assert property (@(posedge oscIn) disable iff (!rstN)
    sinceSys <= HOLD);

  // R5: the half-rate tap toggles only when sysClkOut falls
  assert_half_on_fall_R5: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(halfClkOut) |-> $fell(sysClkOut));

  // R5: every fall of sysClkOut toggles the half-rate tap
  assert_fall_moves_half_R5: assert property (@(posedge oscIn) disable iff (!rstN)
    $fell(sysClkOut) |-> !$stable(halfClkOut));

  // R6: blink edges coincide with system-clock edges
  assert_blink_aligned_R6: assert property (@(posedge oscIn) disable iff (!rstN)
    !$stable(blinkClkOut) |-> !$stable(sysClkOut));
endmodule

bind lamp_clk_gen lamp_clk_gen_chk #(.DIV_FAST(DIV_FAST)) uChk (
  .oscIn      (oscIn),
  .rstN       (rstN),
  .sysClkOut  (sysClkOut),
  .blinkClkOut(blinkClkOut),
  .halfClkOut (halfClkOut)
);

// File: tb/sim_lamp_clk_gen.sv
`timescale 1ns/1ps
module sim_lamp_clk_gen;
  localparam int NF = 5;
  localparam int NS = 3;

  logic oscIn = 1'b0;
  logic rstN  = 1'b0;
  logic oscOut, sysClkOut, blinkClkOut, halfClkOut;

  int total = 0;
  int bad   = 0;
  int k     = 0;
  bit done  = 1'b0;

  lamp_clk_gen #(.DIV_FAST(NF), .DIV_SLOW(NS)) u0 (
    .oscIn(oscIn), .rstN(rstN), .oscOut(oscOut),
    .sysClkOut(sysClkOut), .blinkClkOut(blinkClkOut), .halfClkOut(halfClkOut)
  );

  always #2 oscIn = ~oscIn;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at k=%0d: actual=%b expected=%b", req, what, k, act, exp);
    end
  endtask

  // Reference model, evaluated after k edges since release.
  task automatic checkAll();
    chk("R1", "oscOut", oscOut, oscIn);
    chk("R3", "sysClkOut", sysClkOut, logic'((k / NF) % 2));
    chk("R4", "blinkClkOut", blinkClkOut, logic'((k / (NF * NS)) % 2));
    chk("R5", "halfClkOut", halfClkOut, logic'((k / (2 * NF)) % 2));
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge oscIn);
      if (rstN) k++;
      #1;
      chk("R1", "oscOut high phase", oscOut, oscIn);
      @(negedge oscIn);
      checkAll();
    end
  endtask

  initial begin
    repeat (3) @(negedge oscIn);
    // R2: outputs cleared while held in reset
    chk("R2", "sysClkOut in reset", sysClkOut, 1'b0);
    chk("R2", "blinkClkOut in reset", blinkClkOut, 1'b0);
    chk("R2", "halfClkOut in reset", halfClkOut, 1'b0);
    rstN = 1'b1;
    k = 0;
    runCycles(4 * NF * NS + 7);  // two full blink periods and more
    // Reach a point where sysClkOut is high, then assert reset mid-cycle.
    while (((k / NF) % 2) == 0) runCycles(1);
    #1 rstN = 1'b0;
    #0.5;
    // R2: clearing is asynchronous, with no oscillator edge in between
    chk("R2", "sysClkOut async clear", sysClkOut, 1'b0);
    chk("R2", "blinkClkOut async clear", blinkClkOut, 1'b0);
    chk("R2", "halfClkOut async clear", halfClkOut, 1'b0);
    repeat (2) @(negedge oscIn);
    rstN = 1'b1;
    k = 0;
    // R7: the count restarts from zero after release
    runCycles(2 * NF * NS + 3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule